// File: doc/BRIEF.md
# Overhead Byte Persistence Filter and Interrupt Bank

This block sits behind a receive framer and watches two pieces of line overhead that arrive once per frame: the synchronisation-status byte (S1) and the automatic-protection-switching byte pair (K1 and K2). A value is taken as the new accepted value only after the same value has arrived in a programmable number of consecutive frames. The default is eight. If too many frames go by without any value holding steady, the block flags that byte as unstable. The flag clears at the next acceptance.

The block also takes the line AIS and line RDI defect levels from an external detector. Each event source sets a sticky pending bit: a newly accepted value, an unstable flag being declared or cleared, and a change of either line defect. A single interrupt output is driven high while any pending bit has its enable set. A small register port lets software set the enables, read the accepted values and the live status, and clear pending bits by writing ones.

Top module: `ovh_persist_irq`

## Requirements
- R1: The accepted S1 value, read at address 4, changes only after the same S1 byte has arrived in 8 consecutive valid frames. Fewer repeats leave it unchanged.
- R2: A byte that differs from the current candidate restarts the run at one frame, with the new byte as the candidate.
- R3: Pending bit 7 at address 2 (new S1) sets when a value is accepted that differs from the accepted S1 value. A steady run of the value already accepted never sets it.
- R4: K1 and K2 are filtered together as one 16-bit pair, so a change in either byte restarts the run. The accepted K1 and K2 read at addresses 5 and 6. A new accepted pair sets pending bit 0 at address 2.
- R5: After 32 consecutive valid frames in which no value has held for 8 frames, the unstable flag is declared. The flag shows at address 7, bit 3 for S1 and bit 2 for K1/K2. On declaration, pending bit 6 (S1) or bit 1 (K1/K2) at address 2 sets.
- R6: The unstable flag clears when a value is next accepted, and that clearing sets the same pending bit again.
- R7: Each change of the line AIS level sets pending bit 1 at address 3, in both directions. Each change of the line RDI level sets pending bit 0 at address 3. The current levels read at address 7, bit 1 for AIS and bit 0 for RDI.
- R8: The enables are read/write. Address 0 holds bits 7, 6, 1 and 0, which match the pending bits at address 2. Address 1 holds bits 1 and 0, which match address 3. All other bits, bit 2 of address 0 among them, read 0. All enables reset to 0.
- R9: Pending bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it as it is.
- R10: Pending bits set whatever their enables hold. The interrupt output is high exactly when some pending bit has its enable set.
- R11: After reset, every register reads 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s1_valid | input | 1 | S1 byte present this cycle (once per frame) |
| s1_byte | input | 8 | Received S1 byte |
| kk_valid | input | 1 | K1/K2 pair present this cycle (once per frame) |
| k1_byte | input | 8 | Received K1 byte |
| k2_byte | input | 8 | Received K2 byte |
| ais_lvl | input | 1 | Line AIS defect level from the detector |
| rdi_lvl | input | 1 | Line RDI defect level from the detector |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | OR of all enabled pending bits |

## Verification
The bench sweeps the length of the run from 1 to 10 frames. A filter that is off by one would accept after 7 or 9 repeats. It breaks a run of 7 with a single different byte, so a design that does not restart the count accepts too early. For the K pair it changes only K2, so a filter that compares just K1 would accept. It repeats the value already accepted to show that no spurious new-value event fires. It counts exactly 31 and then 32 unsettled frames to pin down the unstable threshold, and it watches both the declaration and the clearing events, because a design that signals only one edge would lose the other. It toggles the line defects both ways, writes zeros and ones to the pending bits, and moves the enables to show that the interrupt output follows only enabled pending bits.

// File: rtl/ohm_pkg.sv
package ohm_pkg;
  localparam int NSRC        = 6;
  localparam int SRC_NEW_K   = 0;
  localparam int SRC_K_UNST  = 1;
  localparam int SRC_RDI     = 2;
  localparam int SRC_AIS     = 3;
  localparam int SRC_S1_UNST = 4;
  localparam int SRC_NEW_S1  = 5;

  typedef enum logic [2:0] {
    RA_EN_A   = 3'd0,
    RA_EN_B   = 3'd1,
    RA_PEND_A = 3'd2,
    RA_PEND_B = 3'd3,
    RA_S1     = 3'd4,
    RA_K1     = 3'd5,
    RA_K2     = 3'd6,
    RA_STAT   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/ohm_persist_filter.sv
module ohm_persist_filter #(
  parameter int W        = 8,
  parameter int PERSIST  = 8,
  parameter int UNST_LIM = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_value,
  output logic [W-1:0] acc_value,
  output logic         unstable,
  output logic         new_evt
);
  localparam int CW = $clog2(PERSIST + 1);
  localparam int UW = $clog2(UNST_LIM + 1);
  localparam logic [CW-1:0] PMAX = CW'(PERSIST);
  localparam logic [UW-1:0] UMAX = UW'(UNST_LIM);

  logic [W-1:0]  cand_q, cand_n, acc_q, acc_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [UW-1:0] ucnt_q, ucnt_n;
  logic          unst_q, unst_n;
  logic          same, hit;

  always_comb begin
    cand_n  = cand_q;
    cnt_n   = cnt_q;
    acc_n   = acc_q;
    ucnt_n  = ucnt_q;
    unst_n  = unst_q;
    new_evt = 1'b0;
    hit     = 1'b0;
    same    = (in_value == cand_q);
    if (in_valid) begin
      if (same) begin
        cnt_n = (cnt_q == PMAX) ? PMAX : cnt_q + CW'(1);
      end else begin
        cand_n = in_value;
        cnt_n  = CW'(1);
      end
      hit = (cnt_n == PMAX) && !(same && (cnt_q == PMAX));
      if (cnt_n == PMAX) begin
        ucnt_n = '0;
      end else if (ucnt_q != UMAX) begin
        ucnt_n = ucnt_q + UW'(1);
      end
      if (hit) begin
        unst_n = 1'b0;
        if (in_value != acc_q) begin
          acc_n   = in_value;
          new_evt = 1'b1;
        end
      end else if (ucnt_n == UMAX) begin
        unst_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
      ucnt_q <= '0;
      unst_q <= 1'b0;
    end else if (in_valid) begin
      cand_q <= cand_n;
      cnt_q  <= cnt_n;
      acc_q  <= acc_n;
      ucnt_q <= ucnt_n;
      unst_q <= unst_n;
    end
  end

  assign acc_value = acc_q;
  assign unstable  = unst_q;

  // R1
  acc_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q != $past(acc_q)) |-> $past(in_valid));
  // R2
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PMAX);
  // R5
  unst_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unst_q) |-> ($past(in_valid) && ($past(cnt_q) != PMAX)));
endmodule

// File: rtl/ohm_level_change.sv
module ohm_level_change #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_in,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] chg
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_in;
  end

  assign lvl_q = prev_q;
  assign chg   = lvl_in ^ prev_q;
endmodule

// File: rtl/ohm_irq_bank.sv
module ohm_irq_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] en_wmask,
  input  logic [N-1:0] en_wdata,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] en,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] en_q, en_n, pend_q, pend_n;

  always_comb begin
    en_n   = (en_q & ~en_wmask) | (en_wdata & en_wmask);
    pend_n = (pend_q & ~clr_vec) | set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= en_n;
      pend_q <= pend_n;
    end
  end

  assign en   = en_q;
  assign pend = pend_q;
  assign irq  = |(pend_q & en_q);

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R9
    pend_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q[i]) |-> $past(clr_vec[i]));
    // R8
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] != $past(en_q[i])) |-> $past(en_wmask[i]));
  end
endmodule

// File: rtl/ovh_persist_irq.sv
module ovh_persist_irq
  import ohm_pkg::*;
#(
  parameter int PERSIST  = 8,
  parameter int UNST_LIM = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s1_valid,
  input  logic [7:0] s1_byte,
  input  logic       kk_valid,
  input  logic [7:0] k1_byte,
  input  logic [7:0] k2_byte,
  input  logic       ais_lvl,
  input  logic       rdi_lvl,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [7:0]  s1_acc;
  logic [15:0] kk_acc;
  logic        s1_unst, kk_unst, s1_new, kk_new;

  ohm_persist_filter #(.W(8), .PERSIST(PERSIST), .UNST_LIM(UNST_LIM)) u_s1 (
    .clk(clk), .rst_n(rst_n_i), .in_valid(s1_valid), .in_value(s1_byte),
    .acc_value(s1_acc), .unstable(s1_unst), .new_evt(s1_new));

  ohm_persist_filter #(.W(16), .PERSIST(PERSIST), .UNST_LIM(UNST_LIM)) u_kk (
    .clk(clk), .rst_n(rst_n_i), .in_valid(kk_valid), .in_value({k1_byte, k2_byte}),
    .acc_value(kk_acc), .unstable(kk_unst), .new_evt(kk_new));

  logic [3:0] lvl_q, lvl_chg;

  ohm_level_change #(.N(4)) u_chg (
    .clk(clk), .rst_n(rst_n_i),
    .lvl_in({s1_unst, kk_unst, ais_lvl, rdi_lvl}),
    .lvl_q(lvl_q), .chg(lvl_chg));

  logic [NSRC-1:0] set_evt, vec_a, vec_b, mask_a, mask_b;
  logic [NSRC-1:0] en_wmask, en_wdata, clr_vec, en, pend;

  always_comb begin
    set_evt              = '0;
    set_evt[SRC_NEW_S1]  = s1_new;
    set_evt[SRC_NEW_K]   = kk_new;
    set_evt[SRC_S1_UNST] = lvl_chg[3];
    set_evt[SRC_K_UNST]  = lvl_chg[2];
    set_evt[SRC_AIS]     = lvl_chg[1];
    set_evt[SRC_RDI]     = lvl_chg[0];

    vec_a              = '0;
    vec_a[SRC_NEW_S1]  = reg_wdata[7];
    vec_a[SRC_S1_UNST] = reg_wdata[6];
    vec_a[SRC_K_UNST]  = reg_wdata[1];
    vec_a[SRC_NEW_K]   = reg_wdata[0];
    vec_b              = '0;
    vec_b[SRC_AIS]     = reg_wdata[1];
    vec_b[SRC_RDI]     = reg_wdata[0];

    mask_a = '0;
    mask_a[SRC_NEW_S1]  = 1'b1;
    mask_a[SRC_S1_UNST] = 1'b1;
    mask_a[SRC_K_UNST]  = 1'b1;
    mask_a[SRC_NEW_K]   = 1'b1;
    mask_b = '0;
    mask_b[SRC_AIS] = 1'b1;
    mask_b[SRC_RDI] = 1'b1;

    en_wmask = '0;
    en_wdata = vec_a;
    clr_vec  = '0;
    if (reg_wr) begin
      case (reg_addr)
        RA_EN_A:   en_wmask = mask_a;
        RA_EN_B:   begin en_wmask = mask_b; en_wdata = vec_b; end
        RA_PEND_A: clr_vec = vec_a;
        RA_PEND_B: clr_vec = vec_b;
        default:   ;
      endcase
    end
  end

  ohm_irq_bank #(.N(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n_i), .set_evt(set_evt),
    .en_wmask(en_wmask), .en_wdata(en_wdata), .clr_vec(clr_vec),
    .en(en), .pend(pend), .irq(irq));

  function automatic logic [7:0] pack_a(input logic [NSRC-1:0] v);
    return {v[SRC_NEW_S1], v[SRC_S1_UNST], 4'b0000, v[SRC_K_UNST], v[SRC_NEW_K]};
  endfunction

  function automatic logic [7:0] pack_b(input logic [NSRC-1:0] v);
    return {6'b000000, v[SRC_AIS], v[SRC_RDI]};
  endfunction

  always_comb begin
    case (reg_addr)
      RA_EN_A:   reg_rdata = pack_a(en);
      RA_EN_B:   reg_rdata = pack_b(en);
      RA_PEND_A: reg_rdata = pack_a(pend);
      RA_PEND_B: reg_rdata = pack_b(pend);
      RA_S1:     reg_rdata = s1_acc;
      RA_K1:     reg_rdata = kk_acc[15:8];
      RA_K2:     reg_rdata = kk_acc[7:0];
      default:   reg_rdata = {4'b0000, lvl_q};
    endcase
  end
endmodule

// File: tb/tb_ovh_persist_irq.sv
module tb_ovh_persist_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s1_valid = 1'b0, kk_valid = 1'b0;
  logic [7:0] s1_byte = '0, k1_byte = '0, k2_byte = '0;
  logic       ais_lvl = 1'b0, rdi_lvl = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ovh_persist_irq dut (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_byte(s1_byte),
    .kk_valid(kk_valid), .k1_byte(k1_byte), .k2_byte(k2_byte),
    .ais_lvl(ais_lvl), .rdi_lvl(rdi_lvl), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ais_lvl = 1'b0; rdi_lvl = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic send_s1(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); s1_valid = 1'b1; s1_byte = b;
      @(negedge clk); s1_valid = 1'b0;
    end
    settle();
  endtask

  task automatic send_kk(input logic [7:0] a, input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); kk_valid = 1'b1; k1_byte = a; k2_byte = b;
      @(negedge clk); kk_valid = 1'b0;
    end
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    do_reset();
    // R11: reset state of every register
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); check("R11 reg", d, 8'h00);
    end
    check("R11 irq", {7'b0, irq}, 8'h00);

    // R8: enable read/write, unused bits read 0
    wr(3'd0, 8'hFF); rd(3'd0, d); check("R8 enA", d, 8'hC3);
    wr(3'd1, 8'hFF); rd(3'd1, d); check("R8 enB", d, 8'h03);
    wr(3'd0, 8'h04); rd(3'd0, d); check("R8 bit2", d, 8'h00);
    wr(3'd1, 8'h00); rd(3'd1, d); check("R8 enB off", d, 8'h00);

    // R1: sweep run length 1..10
    for (int n = 1; n <= 10; n++) begin
      do_reset();
      send_s1(8'hA5, n);
      rd(3'd4, d); check("R1 accept", d, (n >= 8) ? 8'hA5 : 8'h00);
      rd(3'd2, d); check("R3 new pend", d, (n >= 8) ? 8'h80 : 8'h00);
    end

    // R2: break in a run restarts the count
    do_reset();
    send_s1(8'h3C, 7); send_s1(8'h5A, 1); send_s1(8'h3C, 7);
    rd(3'd4, d); check("R2 restart", d, 8'h00);
    send_s1(8'h3C, 1);
    rd(3'd4, d); check("R2 eighth", d, 8'h3C);

    // R3: repeat of accepted value raises nothing
    do_reset();
    send_s1(8'h00, 8);
    rd(3'd2, d); check("R3 same as reset", d, 8'h00);
    send_s1(8'h77, 8);
    rd(3'd2, d); check("R3 new", d, 8'h80);
    // R9: write 0 keeps, write 1 clears
    wr(3'd2, 8'h00); rd(3'd2, d); check("R9 w0", d, 8'h80);
    wr(3'd2, 8'h80); rd(3'd2, d); check("R9 w1", d, 8'h00);
    send_s1(8'h77, 8);
    rd(3'd2, d); check("R3 steady", d, 8'h00);
    send_s1(8'h11, 8);
    rd(3'd4, d); check("R3 acc2", d, 8'h11);

    // R4: K pair as one 16-bit value
    for (int i = 0; i < 4; i++) begin
      logic [7:0] ka, kb;
      ka = 8'(8'h12 + 8'(i * 17)); kb = 8'(8'h34 + 8'(i * 5));
      do_reset();
      send_kk(ka, kb, 7); send_kk(ka, 8'(kb + 8'd1), 1); send_kk(ka, kb, 7);
      rd(3'd5, d); check("R4 k2 break", d, 8'h00);
      send_kk(ka, kb, 1);
      rd(3'd5, d); check("R4 k1", d, ka);
      rd(3'd6, d); check("R4 k2", d, kb);
      rd(3'd2, d); check("R4 pend", d, 8'h01);
    end

    // R5/R6: S1 unstable threshold and clearing
    do_reset();
    for (int i = 0; i < 31; i++) send_s1(8'(8'h40 + 8'(i)), 1);
    rd(3'd7, d); check("R5 31 frames", d, 8'h00);
    send_s1(8'hF0, 1);
    rd(3'd7, d); check("R5 32 frames", d, 8'h08);
    rd(3'd2, d); check("R5 pend s1", d, 8'h40);
    wr(3'd2, 8'h40);
    send_s1(8'h22, 7);
    rd(3'd7, d); check("R6 still", d, 8'h08);
    send_s1(8'h22, 1);
    rd(3'd7, d); check("R6 cleared", d, 8'h00);
    rd(3'd2, d); check("R6 pend", d, 8'hC0);

    // R5/R6: K pair unstable
    do_reset();
    for (int i = 0; i < 32; i++) send_kk(8'h01, 8'(i), 1);
    rd(3'd7, d); check("R5 k stat", d, 8'h04);
    rd(3'd2, d); check("R5 k pend", d, 8'h02);
    wr(3'd2, 8'h02);
    send_kk(8'h55, 8'h66, 8);
    rd(3'd7, d); check("R6 k clear", d, 8'h00);
    rd(3'd2, d); check("R6 k pend", d, 8'h03);

    // R7: AIS/RDI change both directions
    do_reset();
    @(negedge clk); ais_lvl = 1'b1; settle();
    rd(3'd3, d); check("R7 ais rise", d, 8'h02);
    rd(3'd7, d); check("R7 ais lvl", d, 8'h02);
    wr(3'd3, 8'h02);
    @(negedge clk); ais_lvl = 1'b0; settle();
    rd(3'd3, d); check("R7 ais fall", d, 8'h02);
    wr(3'd3, 8'h02);
    @(negedge clk); rdi_lvl = 1'b1; settle();
    rd(3'd3, d); check("R7 rdi rise", d, 8'h01);
    wr(3'd3, 8'h01);
    @(negedge clk); rdi_lvl = 1'b0; settle();
    rd(3'd3, d); check("R7 rdi fall", d, 8'h01);

    // R10: irq only from enabled pending bits
    check("R10 masked", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h02); #1 check("R10 other en", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h01); #1 check("R10 enabled", {7'b0, irq}, 8'h01);
    wr(3'd3, 8'h01); #1 check("R10 cleared", {7'b0, irq}, 8'h00);
    wr(3'd0, 8'h80);
    send_s1(8'h99, 8);
    check("R10 new s1", {7'b0, irq}, 8'h01);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule